// File: doc/BRIEF.md
# Multi-Level Radix Page Table Walker

The walker turns an input address into a translated address by descending a radix tree held in memory. Software or a translation front end presents the root directory base, the root index width and a two-part root size code, then pulses a start strobe. The walker fetches one 64-bit entry per level over a simple request/response memory port. It follows directory entries until it reaches a leaf, and then reports the leaf entry, the address it was read from, the page size in bits and the translated address.

The tree geometry is not fixed. Every directory entry carries the index width of the level below it. The bit budget left for indexing shrinks by the current index width at each level, and whatever remains when a leaf is found is the page size. Malformed trees abort the walk with a fault code instead of a result: entries that are not valid, index widths that are too small or too large, and chains that are too deep.

Top module: `rtw_walker`

## Requirements
- R1: After reset the walker is idle: `busy_o`, `done_o`, `fault_o` and `mem_req_valid_o` are all 0.
- R2: The starting size in bits equals 31 plus the 5-bit value formed with `root_rts_hi_i` as bits 4:3 and `root_rts_lo_i` as bits 2:0.
- R3: Each entry is read from base + 8 × index, where index = (address >> (size − width)) masked to the low width bits. At the root, base and width come from the start inputs.
- R4: A width below 5, at the root or at any deeper level, ends the walk with `fault_cause_o` = 2'b10 (bad configuration) and no further read. At the root, no read is issued at all.
- R5: An entry whose bit 63 (valid) is 0 ends the walk with `fault_cause_o` = 2'b01 (no entry).
- R6: A valid entry with bit 62 (leaf) clear is a directory. The remaining size drops by the current width, the next width is entry bits 4:0, and the next base is entry bits ADDR_W-1:8 with the low 8 bits zero.
- R7: For a valid entry with bit 62 set, `page_size_o` is the remaining size minus the current width. `trans_addr_o` is the entry's page number (bits ADDR_W-1:12, low 12 bits zero) with its low page-size bits replaced by those of the input address. `leaf_entry_o` and `leaf_addr_o` give the entry and its address.
- R8: At most 8 entries are read per walk. A walk that would need a ninth read ends with `fault_cause_o` = 2'b10 after exactly 8 reads.
- R9: A width larger than the remaining size ends the walk with `fault_cause_o` = 2'b10.
- R10: At most one read is outstanding. `mem_req_valid_o` and `mem_req_addr_o` hold steady until `mem_req_ready_i`, and no new request is made before the response.
- R11: Each accepted start produces exactly one single-cycle pulse of `done_o` or `fault_o`, never both. A start strobe while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a walk (accepted when idle) |
| va_i | input | VA_W | Address to translate |
| root_base_i | input | ADDR_W | Root directory base address |
| root_nls_i | input | 5 | Root index width |
| root_rts_hi_i | input | 2 | Upper part of root size code |
| root_rts_lo_i | input | 3 | Lower part of root size code |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle success pulse |
| fault_o | output | 1 | One-cycle fault pulse |
| fault_cause_o | output | 2 | bit0 no entry, bit1 bad configuration |
| leaf_entry_o | output | 64 | Leaf entry found |
| leaf_addr_o | output | ADDR_W | Address of the leaf entry |
| page_size_o | output | 7 | Page size in bits |
| trans_addr_o | output | ADDR_W | Translated address |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | ADDR_W | Read address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Read data |

## Verification
The hardest situation to reach is the depth limit. With a small size budget, the too-wide check fires long before eight levels are used. The bench therefore starts with the largest size code (62 bits) and points a root entry back at its own directory. It chooses an address whose every 5-bit index group selects that self-referencing entry, so the walk circles until the limit stops it after eight reads. The mid-tree configuration faults are reached the same way, with deliberately bad entries placed at chosen second-level slots. The memory model alternates its ready line and adds response latency, which keeps the request stable across stalled cycles.

// File: rtl/rtw_pkg.sv
package rtw_pkg;

    localparam int ENTRY_W   = 64;
    localparam int NLS_W     = 5;
    localparam int SIZE_W    = 7;
    localparam int MIN_NLS   = 5;
    localparam int SIZE_BIAS = 31;
    localparam int VALID_BIT = 63;
    localparam int LEAF_BIT  = 62;
    localparam int BASE_LSB  = 8;
    localparam int RPN_LSB   = 12;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_READ,
        S_WAIT,
        S_EVAL,
        S_DONE,
        S_FAULT
    } walk_state_t;

    typedef struct packed {
        logic bad_cfg;
        logic no_entry;
    } fault_cause_t;

    function automatic logic [SIZE_W-1:0] start_size(input logic [1:0] hi,
                                                     input logic [2:0] lo);
        return SIZE_W'(SIZE_BIAS) + SIZE_W'({hi, lo});
    endfunction

    function automatic logic entry_valid(input logic [ENTRY_W-1:0] e);
        return e[VALID_BIT];
    endfunction

    function automatic logic entry_leaf(input logic [ENTRY_W-1:0] e);
        return e[LEAF_BIT];
    endfunction

    function automatic logic [NLS_W-1:0] entry_width(input logic [ENTRY_W-1:0] e);
        return e[NLS_W-1:0];
    endfunction

endpackage

// File: rtl/rtw_index_gen.sv
module rtw_index_gen
    import rtw_pkg::*;
#(
    parameter int VA_W   = 64,
    parameter int ADDR_W = 56
) (
    input  logic [VA_W-1:0]   va_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [NLS_W-1:0]  width_i,
    output logic [ADDR_W-1:0] entry_addr_o,
    output logic              width_ok_o
);
    localparam int IDX_KEEP = ADDR_W - 3;

    logic [SIZE_W-1:0] shift;
    logic [VA_W-1:0]   mask;
    logic [VA_W-1:0]   index;

    always_comb begin
        shift        = size_i - SIZE_W'(width_i);
        mask         = (VA_W'(1) << width_i) - VA_W'(1);
        index        = (va_i >> shift) & mask;
        entry_addr_o = base_i + {index[IDX_KEEP-1:0], 3'b000};
        width_ok_o   = (width_i >= NLS_W'(MIN_NLS)) && (SIZE_W'(width_i) <= size_i);
    end

    initial begin
        a_r3_width_fit : assert (VA_W >= ADDR_W - 3)
            else $error("R3: address width too large for index path");
    end

endmodule

// File: rtl/rtw_leaf_compose.sv
module rtw_leaf_compose
    import rtw_pkg::*;
#(
    parameter int VA_W   = 64,
    parameter int ADDR_W = 56
) (
    input  logic [ENTRY_W-1:0] entry_i,
    input  logic [VA_W-1:0]    va_i,
    input  logic [SIZE_W-1:0]  psize_i,
    output logic [ADDR_W-1:0]  trans_o
);
    logic [ADDR_W-1:0] page_base;
    logic [ADDR_W-1:0] low_mask;

    always_comb begin
        page_base = {entry_i[ADDR_W-1:RPN_LSB], {RPN_LSB{1'b0}}};
        low_mask  = (ADDR_W'(1) << psize_i) - ADDR_W'(1);
        trans_o   = (page_base & ~low_mask) | (va_i[ADDR_W-1:0] & low_mask);
    end

endmodule

// File: rtl/rtw_walker.sv
module rtw_walker
    import rtw_pkg::*;
#(
    parameter int VA_W       = 64,
    parameter int ADDR_W     = 56,
    parameter int MAX_LEVELS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [VA_W-1:0]      va_i,
    input  logic [ADDR_W-1:0]    root_base_i,
    input  logic [NLS_W-1:0]     root_nls_i,
    input  logic [1:0]           root_rts_hi_i,
    input  logic [2:0]           root_rts_lo_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 fault_o,
    output logic [1:0]           fault_cause_o,
    output logic [ENTRY_W-1:0]   leaf_entry_o,
    output logic [ADDR_W-1:0]    leaf_addr_o,
    output logic [SIZE_W-1:0]    page_size_o,
    output logic [ADDR_W-1:0]    trans_addr_o,
    output logic                 mem_req_valid_o,
    input  logic                 mem_req_ready_i,
    output logic [ADDR_W-1:0]    mem_req_addr_o,
    input  logic                 mem_rsp_valid_i,
    input  logic [ENTRY_W-1:0]   mem_rsp_data_i
);
    localparam int LVL_W = $clog2(MAX_LEVELS + 1);

    walk_state_t        state_q;
    logic [VA_W-1:0]    va_q;
    logic [ADDR_W-1:0]  base_q;
    logic [NLS_W-1:0]   width_q;
    logic [SIZE_W-1:0]  size_q;
    logic [LVL_W-1:0]   level_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [ENTRY_W-1:0] entry_q;
    fault_cause_t       cause_q;

    logic [ADDR_W-1:0]  next_addr;
    logic               width_ok;
    logic [SIZE_W-1:0]  size_left;
    logic [ADDR_W-1:0]  leaf_trans;

    rtw_index_gen #(.VA_W(VA_W), .ADDR_W(ADDR_W)) u_index (
        .va_i         (va_q),
        .base_i       (base_q),
        .size_i       (size_q),
        .width_i      (width_q),
        .entry_addr_o (next_addr),
        .width_ok_o   (width_ok)
    );

    assign size_left = size_q - SIZE_W'(width_q);

    rtw_leaf_compose #(.VA_W(VA_W), .ADDR_W(ADDR_W)) u_leaf (
        .entry_i (entry_q),
        .va_i    (va_q),
        .psize_i (size_left),
        .trans_o (leaf_trans)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_IDLE;
            va_q         <= '0;
            base_q       <= '0;
            width_q      <= '0;
            size_q       <= '0;
            level_q      <= '0;
            addr_q       <= '0;
            entry_q      <= '0;
            cause_q      <= '0;
            leaf_entry_o <= '0;
            leaf_addr_o  <= '0;
            page_size_o  <= '0;
            trans_addr_o <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        va_q    <= va_i;
                        base_q  <= root_base_i;
                        width_q <= root_nls_i;
                        size_q  <= start_size(root_rts_hi_i, root_rts_lo_i);
                        level_q <= '0;
                        cause_q <= '0;
                        state_q <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    if (!width_ok || level_q == LVL_W'(MAX_LEVELS)) begin
                        cause_q <= '{bad_cfg: 1'b1, no_entry: 1'b0};
                        state_q <= S_FAULT;
                    end else begin
                        addr_q  <= next_addr;
                        state_q <= S_READ;
                    end
                end
                S_READ: begin
                    if (mem_req_ready_i) begin
                        state_q <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (mem_rsp_valid_i) begin
                        entry_q <= mem_rsp_data_i;
                        level_q <= level_q + LVL_W'(1);
                        state_q <= S_EVAL;
                    end
                end
                S_EVAL: begin
                    if (!entry_valid(entry_q)) begin
                        cause_q <= '{bad_cfg: 1'b0, no_entry: 1'b1};
                        state_q <= S_FAULT;
                    end else if (entry_leaf(entry_q)) begin
                        size_q       <= size_left;
                        leaf_entry_o <= entry_q;
                        leaf_addr_o  <= addr_q;
                        page_size_o  <= size_left;
                        trans_addr_o <= leaf_trans;
                        state_q      <= S_DONE;
                    end else begin
                        size_q  <= size_left;
                        width_q <= entry_width(entry_q);
                        base_q  <= {entry_q[ADDR_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
                        state_q <= S_CHECK;
                    end
                end
                S_DONE:  state_q <= S_IDLE;
                S_FAULT: state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy_o          = (state_q != S_IDLE);
    assign done_o          = (state_q == S_DONE);
    assign fault_o         = (state_q == S_FAULT);
    assign fault_cause_o   = cause_q;
    assign mem_req_valid_o = (state_q == S_READ);
    assign mem_req_addr_o  = addr_q;

    // R10: a stalled request keeps its address
    a_r10_req_hold : assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

    // R10: no back-to-back requests, a response must come first
    a_r10_one_outstanding : assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o);

    // R3: entries are 8-byte aligned
    a_r3_aligned : assert property (@(posedge clk) disable iff (rst)
        mem_req_valid_o |-> (mem_req_addr_o[2:0] == 3'b000));

    // R11: result pulses are exclusive and last one cycle
    a_r11_exclusive : assert property (@(posedge clk) disable iff (rst)
        !(done_o && fault_o));
    a_r11_single_pulse : assert property (@(posedge clk) disable iff (rst)
        (done_o || fault_o) |=> !(done_o || fault_o));

    // R4, R5, R9: a fault carries exactly one cause
    a_r4_one_cause : assert property (@(posedge clk) disable iff (rst)
        fault_o |-> ($countones(fault_cause_o) == 1));

    // R5: invalid entry leads to the no-entry fault
    a_r5_invalid_fault : assert property (@(posedge clk) disable iff (rst)
        (state_q == S_EVAL && !entry_q[VALID_BIT]) |=> (fault_o && fault_cause_o == 2'b01));

    // R8: never a request beyond the depth limit
    a_r8_depth : assert property (@(posedge clk) disable iff (rst)
        mem_req_valid_o |-> (level_q < LVL_W'(MAX_LEVELS)));

endmodule

// File: tb/rtw_walker_tb.sv
`timescale 1ns/1ps
module rtw_walker_tb_top;
    localparam int VA_W   = 64;
    localparam int ADDR_W = 56;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [VA_W-1:0]   va = '0;
    logic [ADDR_W-1:0] rbase = '0;
    logic [4:0]        rnls = '0;
    logic [1:0]        rhi = '0;
    logic [2:0]        rlo = '0;
    logic              busy, done, fault;
    logic [1:0]        cause;
    logic [63:0]       leaf_entry;
    logic [ADDR_W-1:0] leaf_addr;
    logic [6:0]        psize;
    logic [ADDR_W-1:0] trans;
    logic              req_valid;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr;
    logic              rsp_valid;
    logic [63:0]       rsp_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rtw_walker #(.VA_W(VA_W), .ADDR_W(ADDR_W), .MAX_LEVELS(8)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .va_i(va),
        .root_base_i(rbase), .root_nls_i(rnls),
        .root_rts_hi_i(rhi), .root_rts_lo_i(rlo),
        .busy_o(busy), .done_o(done), .fault_o(fault), .fault_cause_o(cause),
        .leaf_entry_o(leaf_entry), .leaf_addr_o(leaf_addr),
        .page_size_o(psize), .trans_addr_o(trans),
        .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready),
        .mem_req_addr_o(req_addr), .mem_rsp_valid_i(rsp_valid),
        .mem_rsp_data_i(rsp_data)
    );

    // behavioural memory: 1024 words, alternating ready, fixed latency
    logic [63:0]       mem [0:1023];
    logic              ready_q;
    logic              pend;
    logic [2:0]        lat_cnt;
    logic [ADDR_W-1:0] paddr;
    logic [ADDR_W-1:0] first_addr;
    int                read_cnt;
    int                done_cnt;
    int                fault_cnt;

    assign req_ready = ready_q;

    always @(posedge clk) begin
        if (rst) begin
            ready_q   <= 1'b0;
            pend      <= 1'b0;
            lat_cnt   <= '0;
            paddr     <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            read_cnt  <= 0;
            done_cnt  <= 0;
            fault_cnt <= 0;
            first_addr <= '0;
        end else begin
            ready_q   <= ~ready_q;
            rsp_valid <= 1'b0;
            if (done)  done_cnt  <= done_cnt + 1;
            if (fault) fault_cnt <= fault_cnt + 1;
            if (req_valid && req_ready) begin
                pend     <= 1'b1;
                lat_cnt  <= 3'd2;
                paddr    <= req_addr;
                read_cnt <= read_cnt + 1;
                if (!busy_seen_read) first_addr <= req_addr;
            end
            if (pend) begin
                if (lat_cnt == 0) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= (paddr < ADDR_W'(8192)) ? mem[paddr[12:3]] : 64'd0;
                    pend      <= 1'b0;
                end else begin
                    lat_cnt <= lat_cnt - 3'd1;
                end
            end
        end
    end

    // first request of a walk: set when a read is taken, cleared when idle
    logic busy_seen_read;
    always @(posedge clk) begin
        if (rst || !busy) busy_seen_read <= 1'b0;
        else if (req_valid && req_ready) busy_seen_read <= 1'b1;
    end

    function automatic logic [63:0] mk_dir(input logic [63:0] base, input int w);
        return (64'd1 << 63) | base | 64'(w);
    endfunction

    function automatic logic [63:0] mk_leaf(input logic [63:0] phys);
        return (64'd1 << 63) | (64'd1 << 62) | phys;
    endfunction

    function automatic logic [ADDR_W-1:0] exp_trans(input logic [63:0] e,
                                                    input logic [63:0] a, input int ps);
        logic [63:0] m;
        logic [63:0] pg;
        m  = (64'd1 << ps) - 64'd1;
        pg = e & 64'h00FF_FFFF_FFFF_F000;
        return ADDR_W'((pg & ~m) | (a & m));
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    int rd0, dn0, ft0;

    task automatic walk(input logic [63:0] a, input logic [ADDR_W-1:0] b,
                        input int w, input int hi, input int lo, input bit poke_busy);
        int n;
        @(negedge clk);
        rd0 = read_cnt; dn0 = done_cnt; ft0 = fault_cnt;
        va = a; rbase = b; rnls = 5'(w); rhi = 2'(hi); rlo = 3'(lo);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!(done || fault) && n < 2000) begin
            if (poke_busy && n == 2) begin
                va = '0; rnls = 5'd4; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        if (n >= 2000) chk("walk timeout", 0, 1);
    endtask

    task automatic settle_pulses(input int exp_done, input int exp_fault, input string tag);
        @(negedge clk);
        @(negedge clk);
        chk({tag, " R11 done pulses"},  64'(done_cnt - dn0),  64'(exp_done));
        chk({tag, " R11 fault pulses"}, 64'(fault_cnt - ft0), 64'(exp_fault));
    endtask

    localparam logic [63:0] VA_A = (64'd3 << 26) | (64'd7 << 21) | (64'd9 << 16) | 64'h1234;
    localparam logic [63:0] LEAF3 = 64'h0000_0012_3456_7000;
    localparam logic [63:0] LEAF2 = 64'h0000_00AB_C012_3000;

    task automatic t_reset;
        chk("R1 busy",  64'(busy), 0);
        chk("R1 done",  64'(done), 0);
        chk("R1 fault", 64'(fault), 0);
        chk("R1 req",   64'(req_valid), 0);
    endtask

    task automatic t_three_level;   // R3 R6 R7 R10
        walk(VA_A, '0, 5, 0, 0, 1'b0);
        chk("R7 done", 64'(done), 1);
        chk("R3 first addr", 64'(first_addr), 64'h18);
        chk("R6 leaf addr", 64'(leaf_addr), 64'h248);
        chk("R7 page size", 64'(psize), 16);
        chk("R7 leaf entry", leaf_entry, mk_leaf(LEAF3));
        chk("R7 trans", 64'(trans), 64'(exp_trans(LEAF3, VA_A, 16)));
        chk("R10 reads", 64'(read_cnt - rd0), 3);
        settle_pulses(1, 0, "three_level");
    endtask

    task automatic t_huge;   // R7
        logic [63:0] a;
        a = (64'd3 << 26) | (64'd8 << 21) | 64'h1A_BCDE;
        walk(a, '0, 5, 0, 0, 1'b0);
        chk("R7 huge done", 64'(done), 1);
        chk("R7 huge size", 64'(psize), 21);
        chk("R7 huge leaf addr", 64'(leaf_addr), 64'h140);
        chk("R7 huge trans", 64'(trans), 64'(exp_trans(LEAF2, a, 21)));
        chk("R7 huge reads", 64'(read_cnt - rd0), 2);
        settle_pulses(1, 0, "huge");
    endtask

    task automatic t_noent_root;   // R5
        walk(64'd4 << 26, '0, 5, 0, 0, 1'b0);
        chk("R5 root fault", 64'(fault), 1);
        chk("R5 root cause", 64'(cause), 64'b01);
        chk("R5 root reads", 64'(read_cnt - rd0), 1);
        settle_pulses(0, 1, "noent_root");
    endtask

    task automatic t_noent_leaf;   // R5
        walk((64'd3 << 26) | (64'd7 << 21) | (64'd10 << 16), '0, 5, 0, 0, 1'b0);
        chk("R5 leaf cause", 64'(cause), 64'b01);
        chk("R5 leaf reads", 64'(read_cnt - rd0), 3);
        settle_pulses(0, 1, "noent_leaf");
    endtask

    task automatic t_badcfg_root;   // R4
        walk(VA_A, '0, 4, 0, 0, 1'b0);
        chk("R4 root fault", 64'(fault), 1);
        chk("R4 root cause", 64'(cause), 64'b10);
        chk("R4 root no read", 64'(read_cnt - rd0), 0);
        settle_pulses(0, 1, "badcfg_root");
    endtask

    task automatic t_badcfg_mid;   // R4
        walk((64'd3 << 26) | (64'd9 << 21), '0, 5, 0, 0, 1'b0);
        chk("R4 mid cause", 64'(cause), 64'b10);
        chk("R4 mid reads", 64'(read_cnt - rd0), 2);
        settle_pulses(0, 1, "badcfg_mid");
    endtask

    task automatic t_oversize;   // R9
        walk((64'd3 << 26) | (64'd10 << 21), '0, 5, 0, 0, 1'b0);
        chk("R9 cause", 64'(cause), 64'b10);
        chk("R9 reads", 64'(read_cnt - rd0), 2);
        settle_pulses(0, 1, "oversize");
    endtask

    task automatic t_split;   // R2: size 39 from hi=1, lo=0
        walk(VA_A, '0, 13, 1, 0, 1'b0);
        chk("R2 done", 64'(done), 1);
        chk("R2 first addr", 64'(first_addr), 64'h18);
        chk("R2 trans", 64'(trans), 64'(exp_trans(LEAF3, VA_A, 16)));
        settle_pulses(1, 0, "split");
    endtask

    task automatic t_loop;   // R8: size 62, self-referencing root slot 5
        logic [63:0] a;
        a = '0;
        for (int k = 0; k < 12; k++) a |= 64'd5 << (57 - 5 * k);
        walk(a, '0, 5, 3, 7, 1'b0);
        chk("R8 fault", 64'(fault), 1);
        chk("R8 cause", 64'(cause), 64'b10);
        chk("R8 reads", 64'(read_cnt - rd0), 8);
        settle_pulses(0, 1, "loop");
    endtask

    task automatic t_busy;   // R11: start while busy ignored
        walk(VA_A, '0, 5, 0, 0, 1'b1);
        chk("R11 busy done", 64'(done), 1);
        chk("R11 busy trans", 64'(trans), 64'(exp_trans(LEAF3, VA_A, 16)));
        settle_pulses(1, 0, "busy");
        chk("R11 idle after", 64'(busy), 0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        mem[3]  = mk_dir(64'h100, 5);
        mem[5]  = mk_dir(64'h000, 5);
        mem[39] = mk_dir(64'h200, 5);
        mem[40] = mk_leaf(LEAF2);
        mem[41] = mk_dir(64'h300, 3);
        mem[42] = mk_dir(64'h300, 27);
        mem[73] = mk_leaf(LEAF3);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_three_level();
        t_huge();
        t_noent_root();
        t_noent_leaf();
        t_badcfg_root();
        t_badcfg_mid();
        t_oversize();
        t_split();
        t_loop();
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule